// File: doc/BRIEF.md
# Monochrome Bitmap Video Scan-Out

This block produces the raster timing for a fixed monochrome display and turns a one-bit-per-pixel frame buffer kept in shared RAM into a serial pixel stream. A pixel-clock counter and a line counter give horizontal and vertical blanking and sync. While a frame is being drawn, the block asks a memory arbiter for 16-bit words, one per group of 16 pixels. It then shifts each returned word out with its most significant bit first. A set bit is shown black and a clear bit is shown white. The arbiter, the CPU side of the RAM and the analog stage that drives the tube are not part of this block.

By default the raster is 704 clocks by 370 lines, with 512 by 342 of them visible. One frame takes 21,888 bytes. A select input picks between two fixed frame buffer base addresses, by default 0x1A700 for the main buffer and 0x12700 for the alternate one. The select is sampled only once per frame, at the first clock of vertical blanking. A frame therefore always comes entirely from one buffer, which allows tear-free page flipping.

The word request is a valid/ready stream. The block raises `req_valid` together with `req_addr`. It holds both steady until it sees `req_ready` high on a rising clock edge. The block itself is never back-pressured by the pixel side. The returned data is a valid-only stream: `rsp_valid` may be raised in any cycle and the block always takes the word. The arbiter has 16 clock edges from the request appearing to deliver the data, and the last of those edges may be the one that starts the word on screen. If a request is still unaccepted when the next one is due, it is replaced. If no data has arrived by the time the word is due on screen, the word is shown white.

Top module: `mono_scanout`

## Requirements
- R1: One line is H_TOTAL clocks long and its first H_ACTIVE clocks are visible. `hblank` is high for the other clocks of the line. A frame is V_TOTAL lines and `vblank` is high on every line from line V_ACTIVE on. After reset the raster starts at clock 0 of line V_ACTIVE, which is the first blank line. Every output shows the state of the counters one clock later.
- R2: `hsync` is high for HS_WIDTH clocks, starting HS_FRONT clocks after the visible part of a line ends. `vsync` is high for VS_WIDTH whole lines, starting VS_FRONT lines after the last visible line. Each sync is only ever high inside its own blanking interval.
- R3: Visible pixel x of a line shows bit (15 − x mod 16) of that line's word number x/16. Bit 15 is the leftmost pixel. On `pix_black`, 1 means black and 0 means white.
- R4: The word that holds visible pixel x of line y is requested at byte address base + y·(H_ACTIVE/8) + 2·(x/16). Word addresses are always even, and each word is requested once, in display order.
- R5: A word's request first appears on `req_valid` 16 clocks before the word's first pixel appears on `pix_black`. The first word of a line is requested near the end of the previous line, inside its blanking.
- R6: While `req_valid` is high and `req_ready` is low, `req_valid` and `req_addr` stay unchanged. Data that arrives on the same edge that starts the word on screen is displayed without a cycle of delay.
- R7: A word whose data never arrives is shown as 16 white pixels.
- R8: `buf_sel` is sampled at the first clock of vertical blanking: 0 picks MAIN_BASE and 1 picks ALT_BASE. The next frame uses that buffer throughout, and changes of `buf_sel` at any other time have no effect.
- R9: `pix_black` is 0 whenever `hblank` or `vblank` is high.
- R10: While `rst_n` is low, `hblank` and `vblank` are 1, and `pix_black`, `hsync`, `vsync` and `req_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| buf_sel | input | 1 | Frame buffer choice: 0 main, 1 alternate |
| req_valid | output | 1 | Word fetch request valid |
| req_ready | input | 1 | Arbiter accepts the request on this edge |
| req_addr | output | ADDR_W | Byte address of the requested word |
| rsp_valid | input | 1 | Returned word valid |
| rsp_data | input | WORD_W | Returned word |
| pix_black | output | 1 | Serial pixel, 1 = black |
| hblank | output | 1 | Horizontal blanking |
| vblank | output | 1 | Vertical blanking |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |

## Verification
The bench runs a shrunken raster through eight complete frames and compares every output at every clock against a position model. It changes the arbiter's behaviour from frame to frame: instant acceptance with short latency, stalled acceptance, and data that arrives on the very edge its word is loaded. A design with a late bypass would show the previous word, and a shift register reloaded one clock off would slide every word by one pixel. The bench also flips `buf_sel` in the middle of frames and leaves one word unanswered. A design that samples the select continuously would tear between buffers, and one that keeps a stale holding register would repeat the previous word instead of showing white.

// File: rtl/mvs_pkg.sv
package mvs_pkg;
  // Per-clock decode of the raster position.
  typedef struct packed {
    logic h_act;     // column is in the visible span
    logic v_act;     // line is in the visible span
    logic hsync;
    logic vsync;
    logic load;      // first pixel of a word is at this position
    logic fetch;     // a word starting 16 clocks ahead must be requested
    logic vb_start;  // first clock of vertical blanking
  } mvs_tick_t;
endpackage

// File: rtl/mvs_timing.sv
module mvs_timing
  import mvs_pkg::*;
#(
  parameter int H_ACTIVE = 512,
  parameter int H_TOTAL  = 704,
  parameter int V_ACTIVE = 342,
  parameter int V_TOTAL  = 370,
  parameter int HS_FRONT = 16,
  parameter int HS_WIDTH = 64,
  parameter int VS_FRONT = 2,
  parameter int VS_WIDTH = 4,
  parameter int WORD_W   = 16
) (
  input  logic      clk,
  input  logic      rst_n,
  output mvs_tick_t tick
);
  localparam int HW = $clog2(H_TOTAL + 1);
  localparam int VW = $clog2(V_TOTAL + 1);
  localparam int PW = $clog2(WORD_W);
  localparam logic [HW-1:0] H_LAST  = HW'(H_TOTAL - 1);
  localparam logic [HW-1:0] H_ACT   = HW'(H_ACTIVE);
  localparam logic [HW-1:0] H_PRE   = HW'(H_TOTAL - WORD_W);
  localparam logic [HW-1:0] H_LASTF = HW'(H_ACTIVE - WORD_W);
  localparam logic [HW-1:0] HS_ON   = HW'(H_ACTIVE + HS_FRONT);
  localparam logic [HW-1:0] HS_OFF  = HW'(H_ACTIVE + HS_FRONT + HS_WIDTH);
  localparam logic [VW-1:0] V_LAST  = VW'(V_TOTAL - 1);
  localparam logic [VW-1:0] V_ACT   = VW'(V_ACTIVE);
  localparam logic [VW-1:0] V_ACTM1 = VW'(V_ACTIVE - 1);
  localparam logic [VW-1:0] VS_ON   = VW'(V_ACTIVE + VS_FRONT);
  localparam logic [VW-1:0] VS_OFF  = VW'(V_ACTIVE + VS_FRONT + VS_WIDTH);

  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;
  logic          word_edge;
  logic          next_line_vis;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hcnt <= '0;
      vcnt <= V_ACT;
    end else if (hcnt == H_LAST) begin
      hcnt <= '0;
      vcnt <= (vcnt == V_LAST) ? '0 : vcnt + VW'(1);
    end else begin
      hcnt <= hcnt + HW'(1);
    end
  end

  always_comb begin
    word_edge     = (hcnt[PW-1:0] == '0);
    next_line_vis = (vcnt == V_LAST) || (vcnt < V_ACTM1);
    tick.h_act    = (hcnt < H_ACT);
    tick.v_act    = (vcnt < V_ACT);
    tick.hsync    = (hcnt >= HS_ON) && (hcnt < HS_OFF);
    tick.vsync    = (vcnt >= VS_ON) && (vcnt < VS_OFF);
    tick.load     = tick.h_act && tick.v_act && word_edge;
    tick.fetch    = (tick.v_act && word_edge && (hcnt < H_LASTF)) ||
                    ((hcnt == H_PRE) && next_line_vis);
    tick.vb_start = (hcnt == '0) && (vcnt == V_ACT);
  end
endmodule

// File: rtl/mvs_fetch.sv
module mvs_fetch #(
  parameter int          ADDR_W    = 24,
  parameter int          WORD_W    = 16,
  parameter logic [31:0] MAIN_BASE = 32'h0001_A700,
  parameter logic [31:0] ALT_BASE  = 32'h0001_2700
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch,
  input  logic              vb_start,
  input  logic              load,
  input  logic              buf_sel,
  input  logic              req_ready,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_data,
  output logic              req_valid,
  output logic [ADDR_W-1:0] req_addr,
  output logic [WORD_W-1:0] load_word
);
  localparam logic [ADDR_W-1:0] MAIN_A = ADDR_W'(MAIN_BASE);
  localparam logic [ADDR_W-1:0] ALT_A  = ADDR_W'(ALT_BASE);
  localparam logic [ADDR_W-1:0] STEP_A = ADDR_W'(WORD_W / 8);

  logic [ADDR_W-1:0] ptr;
  logic [WORD_W-1:0] hold;
  logic              hold_full;

  // Address pointer and request stream.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= MAIN_A;
      req_valid <= 1'b0;
      req_addr  <= '0;
    end else begin
      if (vb_start) ptr <= buf_sel ? ALT_A : MAIN_A;
      if (fetch) begin
        req_valid <= 1'b1;
        req_addr  <= ptr;
        ptr       <= ptr + STEP_A;
      end else if (req_valid && req_ready) begin
        req_valid <= 1'b0;
      end
    end
  end

  // One-word holding register; a load empties it.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold      <= '0;
      hold_full <= 1'b0;
    end else if (load) begin
      hold_full <= 1'b0;
    end else if (rsp_valid) begin
      hold      <= rsp_data;
      hold_full <= 1'b1;
    end
  end

  // Data landing on the load edge bypasses the holding register.
  always_comb begin
    if (rsp_valid)      load_word = rsp_data;
    else if (hold_full) load_word = hold;
    else                load_word = '0;
  end
endmodule

// File: rtl/mvs_shifter.sv
module mvs_shifter #(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] word,
  input  logic              h_act,
  input  logic              v_act,
  input  logic              hsync_in,
  input  logic              vsync_in,
  output logic              pix_black,
  output logic              hblank,
  output logic              vblank,
  output logic              hsync,
  output logic              vsync
);
  logic [WORD_W-1:0] sreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sreg      <= '0;
      pix_black <= 1'b0;
      hblank    <= 1'b1;
      vblank    <= 1'b1;
      hsync     <= 1'b0;
      vsync     <= 1'b0;
    end else begin
      if (load) begin
        sreg      <= {word[WORD_W-2:0], 1'b0};
        pix_black <= word[WORD_W-1];
      end else begin
        sreg      <= {sreg[WORD_W-2:0], 1'b0};
        pix_black <= h_act && v_act && sreg[WORD_W-1];
      end
      hblank <= !h_act;
      vblank <= !v_act;
      hsync  <= hsync_in;
      vsync  <= vsync_in;
    end
  end
endmodule

// File: rtl/mono_scanout.sv
module mono_scanout
  import mvs_pkg::*;
#(
  parameter int          H_ACTIVE  = 512,
  parameter int          H_TOTAL   = 704,
  parameter int          V_ACTIVE  = 342,
  parameter int          V_TOTAL   = 370,
  parameter int          HS_FRONT  = 16,
  parameter int          HS_WIDTH  = 64,
  parameter int          VS_FRONT  = 2,
  parameter int          VS_WIDTH  = 4,
  parameter int          WORD_W    = 16,
  parameter int          ADDR_W    = 24,
  parameter logic [31:0] MAIN_BASE = 32'h0001_A700,
  parameter logic [31:0] ALT_BASE  = 32'h0001_2700
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_sel,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              rsp_valid,
  input  logic [WORD_W-1:0] rsp_data,
  output logic              pix_black,
  output logic              hblank,
  output logic              vblank,
  output logic              hsync,
  output logic              vsync
);
  mvs_tick_t         tick;
  logic [WORD_W-1:0] load_word;

  mvs_timing #(
    .H_ACTIVE(H_ACTIVE), .H_TOTAL(H_TOTAL), .V_ACTIVE(V_ACTIVE),
    .V_TOTAL(V_TOTAL), .HS_FRONT(HS_FRONT), .HS_WIDTH(HS_WIDTH),
    .VS_FRONT(VS_FRONT), .VS_WIDTH(VS_WIDTH), .WORD_W(WORD_W)
  ) u_timing (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  mvs_fetch #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W),
    .MAIN_BASE(MAIN_BASE), .ALT_BASE(ALT_BASE)
  ) u_fetch (
    .clk(clk), .rst_n(rst_n), .fetch(tick.fetch), .vb_start(tick.vb_start),
    .load(tick.load), .buf_sel(buf_sel), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .req_valid(req_valid),
    .req_addr(req_addr), .load_word(load_word)
  );

  mvs_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(tick.load), .word(load_word),
    .h_act(tick.h_act), .v_act(tick.v_act), .hsync_in(tick.hsync),
    .vsync_in(tick.vsync), .pix_black(pix_black), .hblank(hblank),
    .vblank(vblank), .hsync(hsync), .vsync(vsync)
  );
endmodule

// File: rtl/mvs_checker.sv
module mvs_checker (
  input logic clk,
  input logic rst_n,
  input logic pix_black,
  input logic hblank,
  input logic vblank,
  input logic hsync,
  input logic vsync,
  input logic req_valid,
  input logic req_ready,
  input logic addr_lsb
);
  p_blank_dark_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hblank || vblank) |-> !pix_black);

  p_hsync_in_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |-> hblank);

  p_vsync_in_blank_r2: assert property (@(posedge clk) disable iff (!rst_n)
    vsync |-> vblank);

  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> req_valid);

  p_addr_even_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> !addr_lsb);

  // R1: vertical blanking only changes at the start of a line
  p_vblank_line_start_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(vblank) |-> $fell(hblank));
endmodule

bind mono_scanout mvs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .pix_black(pix_black), .hblank(hblank),
  .vblank(vblank), .hsync(hsync), .vsync(vsync), .req_valid(req_valid),
  .req_ready(req_ready), .addr_lsb(req_addr[0])
);

// File: tb/mono_scanout_tb.sv
module mono_scanout_tb;
  localparam int CLK_NS = 10;
  localparam int HA = 32, HT = 64, VA = 4, VT = 7;
  localparam int HSF = 4, HSW = 8, VSF = 1, VSW = 2;
  localparam int AW = 16;
  localparam int MAIN = 'h0100, ALT = 'h0800;
  localparam int FRAME = HT * VT;
  localparam int LB = HA / 8;
  localparam int RUN = 8 * FRAME + 10;
  localparam logic [7:0] SEL_PLAN = 8'b0110_1001;

  logic clk = 1'b0, rst_n = 1'b0, buf_sel = 1'b0, req_ready = 1'b0, rsp_valid = 1'b0;
  logic [15:0] rsp_data = '0;
  logic req_valid, pix_black, hblank, vblank, hsync, vsync;
  logic [AW-1:0] req_addr;

  int t = 0, errs = 0, checks = 0;
  int base_of [0:15];
  bit pend = 0; int pend_due = 0, pend_addr = 0;
  bit prev_stall = 0; int prev_addr = 0;

  mono_scanout #(
    .H_ACTIVE(HA), .H_TOTAL(HT), .V_ACTIVE(VA), .V_TOTAL(VT),
    .HS_FRONT(HSF), .HS_WIDTH(HSW), .VS_FRONT(VSF), .VS_WIDTH(VSW),
    .WORD_W(16), .ADDR_W(AW), .MAIN_BASE(MAIN), .ALT_BASE(ALT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .buf_sel(buf_sel), .req_valid(req_valid),
    .req_ready(req_ready), .req_addr(req_addr), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .pix_black(pix_black), .hblank(hblank),
    .vblank(vblank), .hsync(hsync), .vsync(vsync)
  );

  always #(CLK_NS/2) clk = ~clk;

  function automatic int mem_word(int a);
    return ((a * 40503) ^ (a >> 3) ^ 'hA5C3) & 'hFFFF;
  endfunction

  function automatic bit is_drop(int f, int a);
    return (f == 3) && (a == base_of[3] + 2 * LB + 2);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h t=%0d", req, act, exp, t);
    end
  endtask

  // Model of the select sampling: position index before this edge.
  always @(posedge clk) begin
    if (rst_n) begin
      if (t % FRAME == 0) base_of[(VA * HT + t) / FRAME + 1] = buf_sel ? ALT : MAIN;
      t++;
    end
  end

  initial begin
    base_of[0] = MAIN;
    for (int i = 1; i < 16; i++) base_of[i] = MAIN;
    repeat (3) begin
      @(negedge clk);
      chk("R10 pix", int'(pix_black), 0);
      chk("R10 hblank", int'(hblank), 1);
      chk("R10 vblank", int'(vblank), 1);
      chk("R10 sync", int'(hsync) + int'(vsync), 0);
      chk("R10 req_valid", int'(req_valid), 0);
    end
    buf_sel = SEL_PLAN[0];
    rst_n = 1'b1;
    for (int n = 0; n < RUN; n++) begin
      int p, h, v, f, mode, lat;
      bit rdy;
      @(negedge clk);
      if (t >= 1) begin
        p = VA * HT + t - 1;
        h = p % HT; v = (p / HT) % VT; f = p / FRAME;
        chk("R1 hblank", int'(hblank), (h >= HA) ? 1 : 0);
        chk("R1 vblank", int'(vblank), (v >= VA) ? 1 : 0);
        chk("R2 hsync", int'(hsync), (h >= HA + HSF && h < HA + HSF + HSW) ? 1 : 0);
        chk("R2 vsync", int'(vsync), (v >= VA + VSF && v < VA + VSF + VSW) ? 1 : 0);
        if (h < HA && v < VA) begin
          int a, w;
          a = base_of[f] + v * LB + (h / 16) * 2;
          w = is_drop(f, a) ? 0 : mem_word(a);
          if (is_drop(f, a)) chk("R7 pix", int'(pix_black), 0);
          else if (f >= 7) chk("R6 pix", int'(pix_black), (w >> (15 - h % 16)) & 1);
          else if (base_of[f] == ALT) chk("R8 pix", int'(pix_black), (w >> (15 - h % 16)) & 1);
          else chk("R3 pix", int'(pix_black), (w >> (15 - h % 16)) & 1);
        end else begin
          chk("R9 pix", int'(pix_black), 0);
        end
        // request checks
        if (prev_stall) begin
          chk("R6 hold valid", int'(req_valid), 1);
          chk("R6 hold addr", int'(req_addr), prev_addr);
        end else if (req_valid) begin
          int q, hq, vq, fq;
          q = p + 16; hq = q % HT; vq = (q / HT) % VT; fq = q / FRAME;
          chk("R5 request lead", (hq % 16 == 0 && hq < HA && vq < VA) ? 1 : 0, 1);
          chk("R4 address", int'(req_addr), base_of[fq] + vq * LB + hq / 8);
        end
        f = p / FRAME;
      end else begin
        f = 0;
      end
      // arbiter behaviour for the upcoming edge
      mode = (f <= 3) ? 0 : (f <= 6) ? 1 : 2;
      lat  = (mode == 0) ? 1 : (mode == 1) ? 6 : 15;
      rdy  = (mode == 1) ? ((t % 3) == 0) : 1'b1;
      req_ready = rdy;
      rsp_valid = 1'b0;
      if (pend && t == pend_due) begin
        rsp_valid = 1'b1;
        rsp_data  = 16'(mem_word(pend_addr));
        pend = 0;
      end
      if (req_valid && rdy && !is_drop(f, int'(req_addr))) begin
        pend = 1; pend_due = t + lat; pend_addr = int'(req_addr);
      end
      prev_stall = req_valid && !rdy;
      prev_addr  = int'(req_addr);
      buf_sel = SEL_PLAN[(t / FRAME) % 8] ^ ((t % FRAME >= 100 && t % FRAME < 300) ? 1'b1 : 1'b0);
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule